// File: doc/BRIEF.md
# Instruction Fetch Remap Unit

This block redirects CPU instruction fetches from the flash address space into fixed 4 KB blocks of on-chip RAM. Each RAM block has its own three-byte remap register holding a 20-bit flash offset and a mode bit. When a block is in fetch mode and a fetch falls inside the 4 KB window at that block's programmed offset, the fetch is sent to the block's RAM. The offset within the window is kept, and the access is marked non-cacheable. Every other fetch passes through unchanged and stays cacheable.

Software programs the registers through a byte-wide port, where each block takes three consecutive byte addresses. The lookup path is purely combinational. It takes a fetch address and returns a hit flag, the translated address and a non-cacheable indication in the same cycle. A block's mapping goes live when its high byte is written with the mode bit cleared. Software must therefore write the low and middle bytes first.

Top module: `fetch_remap`

## Requirements
- R1: After reset every block's low and middle bytes read 0x00 and its high byte reads 0x08 (mode bit set), and no fetch hits.
- R2: The low and middle bytes read back exactly as written. The high byte keeps bits 7 and 3..0, and its bits 6..4 always read as zero.
- R3: Register byte address 3n+0, 3n+1 and 3n+2 selects the low, middle and high byte of block n. Writes to addresses at or above 3×NUM_BLOCKS change nothing, and reads there return 0x00.
- R4: On a hit by block n, the translated address is RAM_BASE + n×0x1000 + fetch address bits 11..0, and the non-cacheable output is 1.
- R5: On a miss, the hit output is 0, the translated address equals the fetch address, and the non-cacheable output is 0.
- R6: While a block's high-byte bit 3 (mode) is 1, that block never redirects.
- R7: The window is selected by flash offset bits 19..12. Bits 15..12 come from middle-byte bits 7..4, bits 18..16 come from high-byte bits 2..0, and bit 19 comes from high-byte bit 7. The window spans exactly 4 KB.
- R8: A block whose programmed offset has any of bits 11..0 nonzero (low byte, or middle-byte bits 3..0) never redirects.
- R9: A fetch whose address does not lie in the 1 MB region starting at FLASH_BASE never hits.
- R10: When several fetch-mode blocks match the same fetch, the lowest-numbered block supplies the translation.
- R11: A register write takes effect at the clock edge on which it is presented. A mapping is therefore live on the cycle after the high-byte write that clears the mode bit, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register byte write strobe |
| regAddr | input | REG_ADDR_W | Register byte address |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data byte for regAddr (combinational) |
| fetchAddr | input | ADDR_W | Instruction fetch address |
| fetchHit | output | 1 | Fetch redirected into a RAM block |
| physAddr | output | ADDR_W | Translated (or unchanged) fetch address |
| nonCacheable | output | 1 | Fetch must bypass the cache |

## Verification
Lookup and read-back results are combinational, so each is due in the same cycle as its stimulus. The bench drives the inputs on the falling edge and samples 1 ns later, well before the next rising edge. A register write is due one rising edge after it is presented. The bench checks its effect only after that edge, during the following low phase. It also checks the same fetch just before the enabling high-byte write, to confirm the mapping is not live early.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    FIELD_LO  = 2'd0,
    FIELD_MID = 2'd1,
    FIELD_HI  = 2'd2
  } fieldSel_e;

  typedef struct packed {
    logic             valid;
    fieldSel_e        field;
    logic [IDX_W-1:0] idx;
    logic             wrLo;
    logic             wrMid;
    logic             wrHi;
    logic [7:0]       data;
  } ctrlStrobes_t;

  localparam logic [7:0] HI_RESET = 8'h08;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int NUM_BLOCKS = 15,
  parameter int REG_ADDR_W = $clog2(3 * NUM_BLOCKS)
) (
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [7:0]            regWrData,
  output ctrlStrobes_t          strobes
);
  localparam int NUM_BYTES = 3 * NUM_BLOCKS;

  always_comb begin
    int unsigned byteAddr;
    byteAddr       = int'(regAddr);
    strobes.valid  = byteAddr < NUM_BYTES;
    strobes.idx    = IDX_W'(byteAddr / 3);
    strobes.field  = fieldSel_e'(2'(byteAddr % 3));
    strobes.data   = regWrData;
    strobes.wrLo   = regWrEn && strobes.valid && (strobes.field == FIELD_LO);
    strobes.wrMid  = regWrEn && strobes.valid && (strobes.field == FIELD_MID);
    strobes.wrHi   = regWrEn && strobes.valid && (strobes.field == FIELD_HI);
  end
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int          NUM_BLOCKS = 15,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] FLASH_BASE = 32'h8000_0000,
  parameter logic [31:0] RAM_BASE   = 32'h8010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [7:0]        regRdData,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchHit,
  output logic [ADDR_W-1:0] physAddr,
  output logic              nonCacheable
);
  localparam int BLOCK_BITS  = 12;
  localparam int REGION_BITS = 20;
  localparam int WIN_W       = REGION_BITS - BLOCK_BITS;
  localparam int BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam logic [ADDR_W-1:0] FLASH_B = ADDR_W'(FLASH_BASE);
  localparam logic [ADDR_W-1:0] RAM_B   = ADDR_W'(RAM_BASE);

  logic [7:0] loReg   [NUM_BLOCKS];
  logic [7:0] midReg  [NUM_BLOCKS];
  logic [3:0] topBits [NUM_BLOCKS];  // offset bits 19..16
  logic       modeBit [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] blockMatch;

  logic                   inRegion;
  logic [REGION_BITS-1:0] fetchOffset;

  assign fetchOffset = fetchAddr[REGION_BITS-1:0];
  assign inRegion    = fetchAddr[ADDR_W-1:REGION_BITS] == FLASH_B[ADDR_W-1:REGION_BITS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : gBlock
    logic selThis;
    logic [WIN_W-1:0] winBase;
    assign selThis = strobes.idx == IDX_W'(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg[g]   <= '0;
        midReg[g]  <= '0;
        topBits[g] <= '0;
        modeBit[g] <= HI_RESET[3];
      end else if (selThis) begin
        if (strobes.wrLo)  loReg[g]  <= strobes.data;
        if (strobes.wrMid) midReg[g] <= strobes.data;
        if (strobes.wrHi) begin
          topBits[g] <= {strobes.data[7], strobes.data[2:0]};
          modeBit[g] <= strobes.data[3];
        end
      end
    end

    assign winBase       = {topBits[g], midReg[g][7:4]};
    assign blockMatch[g] = !modeBit[g] && (loReg[g] == 8'h00) && (midReg[g][3:0] == 4'h0)
                           && (winBase == fetchOffset[REGION_BITS-1:BLOCK_BITS]);
  end

  always_comb begin
    regRdData = 8'h00;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (strobes.valid && strobes.idx == IDX_W'(i)) begin
        unique case (strobes.field)
          FIELD_LO:  regRdData = loReg[i];
          FIELD_MID: regRdData = midReg[i];
          FIELD_HI:  regRdData = {topBits[i][3], 3'b000, modeBit[i], topBits[i][2:0]};
          default:   regRdData = 8'h00;
        endcase
      end
    end
  end

  logic             anyMatch;
  logic [BLK_W-1:0] winIdx;

  always_comb begin
    anyMatch = 1'b0;
    winIdx   = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
      if (blockMatch[i]) begin
        anyMatch = 1'b1;
        winIdx   = BLK_W'(i);
      end
    end
  end

  assign fetchHit     = inRegion && anyMatch;
  assign nonCacheable = fetchHit;
  assign physAddr     = fetchHit
                        ? RAM_B + (ADDR_W'(winIdx) << BLOCK_BITS)
                          + ADDR_W'(fetchAddr[BLOCK_BITS-1:0])
                        : fetchAddr;
endmodule

// File: rtl/fetch_remap.sv
module fetch_remap
  import remap_pkg::*;
#(
  parameter int          NUM_BLOCKS = 15,
  parameter int          ADDR_W     = 32,
  parameter int          REG_ADDR_W = $clog2(3 * NUM_BLOCKS),
  parameter logic [31:0] FLASH_BASE = 32'h8000_0000,
  parameter logic [31:0] RAM_BASE   = 32'h8010_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [7:0]            regWrData,
  output logic [7:0]            regRdData,
  input  logic [ADDR_W-1:0]     fetchAddr,
  output logic                  fetchHit,
  output logic [ADDR_W-1:0]     physAddr,
  output logic                  nonCacheable
);
  ctrlStrobes_t strobes;

  remap_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .REG_ADDR_W(REG_ADDR_W)
  ) uCtrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  remap_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .ADDR_W    (ADDR_W),
    .FLASH_BASE(FLASH_BASE),
    .RAM_BASE  (RAM_BASE)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regRdData   (regRdData),
    .fetchAddr   (fetchAddr),
    .fetchHit    (fetchHit),
    .physAddr    (physAddr),
    .nonCacheable(nonCacheable)
  );
endmodule

// File: rtl/fetch_remap_checker.sv
module fetch_remap_checker #(
  parameter int          NUM_BLOCKS = 15,
  parameter int          ADDR_W     = 32,
  parameter int          REG_ADDR_W = $clog2(3 * NUM_BLOCKS),
  parameter logic [31:0] FLASH_BASE = 32'h8000_0000,
  parameter logic [31:0] RAM_BASE   = 32'h8010_0000
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [7:0]            regRdData,
  input logic [ADDR_W-1:0]     fetchAddr,
  input logic                  fetchHit,
  input logic [ADDR_W-1:0]     physAddr,
  input logic                  nonCacheable
);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE) + ADDR_W'(NUM_BLOCKS * 4096);
  localparam logic [ADDR_W-1:0] FLASH_B = ADDR_W'(FLASH_BASE);

  assert_hit_uncached_R4: assert property (@(posedge clk) disable iff (!rstN)
    fetchHit |-> nonCacheable);

  assert_hit_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    fetchHit |-> (physAddr[11:0] == fetchAddr[11:0]) && (physAddr >= RAM_LO) && (physAddr < RAM_HI));

  assert_miss_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    !fetchHit |-> (physAddr == fetchAddr) && !nonCacheable);

  assert_outside_region_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddr[ADDR_W-1:20] != FLASH_B[ADDR_W-1:20]) |-> !fetchHit);

  assert_hi_unused_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(regAddr) % 3) == 2) |-> (regRdData[6:4] == 3'b000));

  assert_oob_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) >= 3 * NUM_BLOCKS) |-> (regRdData == 8'h00));
endmodule

bind fetch_remap fetch_remap_checker #(
  .NUM_BLOCKS(NUM_BLOCKS),
  .ADDR_W    (ADDR_W),
  .REG_ADDR_W(REG_ADDR_W),
  .FLASH_BASE(FLASH_BASE),
  .RAM_BASE  (RAM_BASE)
) uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .fetchAddr   (fetchAddr),
  .fetchHit    (fetchHit),
  .physAddr    (physAddr),
  .nonCacheable(nonCacheable)
);

// File: tb/fetch_remap_test.sv
`timescale 1ns/1ps
module fetch_remap_test;
  localparam int NB = 15;
  localparam int AW = 32;
  localparam int RAW = $clog2(3 * NB);
  localparam logic [31:0] RAM_B = 32'h8010_0000;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           regWrEn = 1'b0;
  logic [RAW-1:0] regAddr = '0;
  logic [7:0]     regWrData = '0;
  logic [7:0]     regRdData;
  logic [AW-1:0]  fetchAddr = '0;
  logic           fetchHit;
  logic [AW-1:0]  physAddr;
  logic           nonCacheable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fetch_remap uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchAddr(fetchAddr),
    .fetchHit(fetchHit), .physAddr(physAddr), .nonCacheable(nonCacheable)
  );

  task automatic note(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write presented on falling edge, captured on next rising edge
  task automatic writeReg(input int addr, input logic [7:0] val);
    @(negedge clk);
    regAddr = RAW'(addr); regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input int addr, input logic [7:0] exp, input string req);
    regAddr = RAW'(addr);
    #1;
    note(regRdData === exp, req, 32'(regRdData), 32'(exp));
  endtask

  task automatic expectHit(input logic [31:0] fa, input int blk, input string req);
    logic [31:0] exp;
    fetchAddr = fa;
    #1;
    exp = RAM_B + 32'(blk) * 32'h1000 + {20'h0, fa[11:0]};
    note(fetchHit === 1'b1, req, 32'(fetchHit), 32'd1);
    note(physAddr === exp, req, physAddr, exp);
    note(nonCacheable === 1'b1, req, 32'(nonCacheable), 32'd1);
  endtask

  task automatic expectMiss(input logic [31:0] fa, input string req);
    fetchAddr = fa;
    #1;
    note(fetchHit === 1'b0, req, 32'(fetchHit), 32'd0);
    note(physAddr === fa, req, physAddr, fa);
    note(nonCacheable === 1'b0, req, 32'(nonCacheable), 32'd0);
  endtask

  task automatic testReset();
    for (int b = 0; b < NB; b++) begin
      readCheck(3*b,   8'h00, "R1 lo");
      readCheck(3*b+1, 8'h00, "R1 mid");
      readCheck(3*b+2, 8'h08, "R1 hi");
    end
    expectMiss(32'h8000_0000, "R1 no hit");
  endtask

  task automatic testReadback();
    writeReg(6, 8'hA5);
    writeReg(7, 8'h3C);
    writeReg(8, 8'hFF);
    readCheck(6, 8'hA5, "R2 lo");
    readCheck(7, 8'h3C, "R2 mid");
    readCheck(8, 8'h8F, "R2 hi unused bits");
    writeReg(8, 8'h08);
  endtask

  task automatic testDecode();
    writeReg(3*NB, 8'h5A);
    writeReg(3*NB+1, 8'h77);
    readCheck(3*NB, 8'h00, "R3 oob read");
    readCheck(3*NB+1, 8'h00, "R3 oob read");
    readCheck(3*(NB-1), 8'h00, "R3 last lo untouched");
    readCheck(3*(NB-1)+2, 8'h08, "R3 last hi untouched");
    writeReg(3*3+1, 8'h12);
    readCheck(3*3+1, 8'h12, "R3 block3 mid");
    readCheck(3*3, 8'h00, "R3 block3 lo");
    readCheck(3*4+1, 8'h00, "R3 block4 mid");
    writeReg(3*3+1, 8'h00);
  endtask

  task automatic testTranslate();
    writeReg(3*4, 8'h00);
    writeReg(3*4+1, 8'h30);
    expectMiss(32'h8002_3ABC, "R11 before hi write");
    writeReg(3*4+2, 8'h02);
    expectHit(32'h8002_3ABC, 4, "R4 translate");
    expectHit(32'h8002_3000, 4, "R7 window start");
    expectHit(32'h8002_3FFF, 4, "R7 window end");
    expectMiss(32'h8002_4000, "R7 past window");
    expectMiss(32'h8002_2FFF, "R5 before window");
  endtask

  task automatic testBit19();
    writeReg(3*7, 8'h00);
    writeReg(3*7+1, 8'hF0);
    writeReg(3*7+2, 8'h81);
    expectHit(32'h8009_F010, 7, "R7 bit19");
    expectMiss(32'h8001_F010, "R7 bit19 clear");
    writeReg(3*14+1, 8'hF0);
    writeReg(3*14+2, 8'h87);
    expectHit(32'h800F_FFFF, 14, "R4 last block");
  endtask

  task automatic testMode();
    writeReg(3*7+2, 8'h89);
    expectMiss(32'h8009_F010, "R6 mode set");
    writeReg(3*7+2, 8'h81);
    expectHit(32'h8009_F010, 7, "R6 mode cleared");
  endtask

  task automatic testLowBits();
    writeReg(3*9, 8'h01);
    writeReg(3*9+1, 8'h00);
    writeReg(3*9+2, 8'h05);
    expectMiss(32'h8005_0040, "R8 low byte nonzero");
    writeReg(3*9, 8'h00);
    writeReg(3*9+1, 8'h08);
    expectMiss(32'h8005_0040, "R8 mid low nibble nonzero");
    writeReg(3*9+1, 8'h00);
    expectHit(32'h8005_0040, 9, "R8 aligned");
  endtask

  task automatic testPriority();
    writeReg(3*1, 8'h00);
    writeReg(3*1+1, 8'h00);
    writeReg(3*1+2, 8'h05);
    expectHit(32'h8005_0123, 1, "R10 lowest wins");
    writeReg(3*1+2, 8'h0D);
    expectHit(32'h8005_0123, 9, "R10 fallback");
  endtask

  task automatic testOutside();
    expectMiss(32'h8105_0040, "R9 above region");
    expectMiss(32'h7FF5_0040, "R9 below region");
    expectMiss(32'h0005_0040, "R9 far away");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testDecode();
    testTranslate();
    testBit19();
    testMode();
    testLowBits();
    testPriority();
    testOutside();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule